// File: doc/BRIEF.md
# Quad-LUT trigger evaluator

This block decides, on every clock, whether the current sample of sixteen logic channels should raise a trigger. The channels are cut into groups of four. The 4-bit value of each group addresses a 16-entry truth table, and a match term is true only when every group's table returns 1 at its address. Three match terms are evaluated in parallel, each with its own set of group tables. The first term is a level condition that gates the trigger directly; it is normally loaded with a value/mask pattern. The other two are edge slots. They reach the trigger only through a 16-entry glue table, which is addressed by the previous and current state of both slots.

Software loads the tables one row at a time while the block is disarmed. Each write step carries the bit for that row of every group table of every term, together with the glue bit for the same row, so sixteen steps load the whole set. Raising `arm` starts evaluation. The control is a two-state machine. In state LOAD (the block is disarmed, or has just been armed) no trigger can fire. The transition LOAD->WATCH is taken on any clock where `arm` is high. The transition WATCH->LOAD is taken on any clock where `arm` is low. WATCH stays in WATCH while `arm` stays high, and LOAD stays in LOAD while `arm` stays low. The armed sample taken in LOAD supplies the edge history that the first WATCH sample is compared against.

Top module: `trig_lut_eval`

## Requirements
- R1: After reset `trig_out` is 0 and every table, glue included, holds all zeros, so no sample fires until tables are written.
- R2: Group g is formed by channels 4g..4g+3, with channel 4g as address bit 0. A term is true only when, for every group, bit (group value) of that group's table for the term is 1.
- R3: Term 0 (the value/mask term) gates the trigger directly. Terms 1 and 2 are edge slots 0 and 1 and affect the trigger only through the glue table.
- R4: Glue address bit 2n is edge slot n's state on the previous armed sample, and bit 2n+1 is its state on the current sample (n = 0, 1). A slot loaded for rising therefore uses glue rows with bit 2n = 0 and bit 2n+1 = 1.
- R5: `trig_out` is high in the cycle after a sample exactly when that sample was evaluated in WATCH with `arm` high, term 0 true and the glue output true. A condition that holds for one sample gives a one-cycle pulse.
- R6: A glue table holding all zeros is treated as always true.
- R7: On a clock where `wr_en` is 1 and `arm` is 0, row `wr_row` of the table for term t, group g takes `wr_lut_bits[t*4+g]`, and row `wr_row` of the glue takes `wr_glue_bit`. All other rows keep their contents.
- R8: Writes presented while `arm` is 1 change no table.
- R9: The first sample after `arm` rises never fires. When `arm` falls, the next cycle's `trig_out` is 0, and re-arming primes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and table clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | High enables evaluation and locks the tables |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | 4 | Row written this step |
| wr_lut_bits | input | 12 | Row bit for each term/group table, term t group g at bit t*4+g |
| wr_glue_bit | input | 1 | Row bit for the glue table |
| samp_in | input | 16 | Channel sample |
| trig_out | output | 1 | Registered trigger pulse |

## Verification
The bench builds the block with its default of four groups, which gives the full sixteen channels, three terms and a 16-row glue table. With these values it can reach value/mask patterns that span several groups. It can also reach rising and falling slots on channels in different groups, a single-row write that turns one table address on, a complete reload attempted while armed, and the disarm/re-arm priming sequence. A behavioural model mirrors the writes and the history from the ports alone and predicts `trig_out` for every clock, while randomised samples biased toward the programmed patterns produce many matches.

// File: rtl/trig_eval_pkg.sv
package trig_eval_pkg;
    localparam int EDGE_SLOTS = 2;
    localparam int GRP_W      = 2 * EDGE_SLOTS;
    localparam int ROWS       = 1 << GRP_W;
    localparam int NUM_TERMS  = 1 + EDGE_SLOTS;
    localparam int TERM_VM    = 0;

    typedef enum logic {
        ST_LOAD  = 1'b0,
        ST_WATCH = 1'b1
    } arm_state_e;
endpackage

// File: rtl/trig_lut_store.sv
module trig_lut_store
    import trig_eval_pkg::*;
#(
    parameter int NUM_GRP = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 arm,
    input  logic                                 wr_en,
    input  logic [GRP_W-1:0]                     wr_row,
    input  logic [NUM_TERMS*NUM_GRP-1:0]         wr_lut_bits,
    input  logic                                 wr_glue_bit,
    output logic [NUM_TERMS*NUM_GRP*ROWS-1:0]    lut_flat,
    output logic [ROWS-1:0]                      glue_tab
);
    localparam int NUM_TAB = NUM_TERMS * NUM_GRP;

    logic [ROWS-1:0] tab_q [NUM_TAB];
    logic [ROWS-1:0] glue_q;
    logic            wr_ok;

    assign wr_ok = wr_en && !arm;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_TAB; k++) begin
                tab_q[k] <= '0;
            end
            glue_q <= '0;
        end else if (wr_ok) begin
            for (int k = 0; k < NUM_TAB; k++) begin
                tab_q[k][wr_row] <= wr_lut_bits[k];
            end
            glue_q[wr_row] <= wr_glue_bit;
        end
    end

    for (genvar k = 0; k < NUM_TAB; k++) begin : g_flat
        assign lut_flat[k*ROWS +: ROWS] = tab_q[k];
    end
    assign glue_tab = glue_q;

    // R8: tables are frozen across any armed clock
    a_r8_locked_tables: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> ($stable(lut_flat) && $stable(glue_tab)));
endmodule

// File: rtl/trig_term_eval.sv
module trig_term_eval
    import trig_eval_pkg::*;
#(
    parameter int NUM_GRP = 4
) (
    input  logic [NUM_GRP*GRP_W-1:0] samp,
    input  logic [NUM_GRP*ROWS-1:0]  tabs,
    output logic                     term
);
    logic [NUM_GRP-1:0] grp_hit;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic [ROWS-1:0]  grp_tab;
        logic [GRP_W-1:0] grp_idx;
        assign grp_tab    = tabs[g*ROWS +: ROWS];
        assign grp_idx    = samp[g*GRP_W +: GRP_W];
        assign grp_hit[g] = grp_tab[grp_idx];
    end

    assign term = &grp_hit;
endmodule

// File: rtl/trig_glue.sv
module trig_glue
    import trig_eval_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm,
    input  logic [EDGE_SLOTS-1:0] slot_cur,
    input  logic [ROWS-1:0]       glue_tab,
    output logic                  glue_ok
);
    logic [EDGE_SLOTS-1:0] slot_prev_q;
    logic [GRP_W-1:0]      glue_idx;
    logic                  glue_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_prev_q <= '0;
        end else if (arm) begin
            slot_prev_q <= slot_cur;
        end
    end

    always_comb begin
        for (int n = 0; n < EDGE_SLOTS; n++) begin
            glue_idx[2*n]     = slot_prev_q[n];
            glue_idx[2*n + 1] = slot_cur[n];
        end
    end

    assign glue_empty = (glue_tab == '0);
    assign glue_ok    = glue_empty || glue_tab[glue_idx];
endmodule

// File: rtl/trig_lut_eval.sv
module trig_lut_eval
    import trig_eval_pkg::*;
#(
    parameter int NUM_GRP = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         arm,
    input  logic                         wr_en,
    input  logic [GRP_W-1:0]             wr_row,
    input  logic [NUM_TERMS*NUM_GRP-1:0] wr_lut_bits,
    input  logic                         wr_glue_bit,
    input  logic [NUM_GRP*GRP_W-1:0]     samp_in,
    output logic                         trig_out
);
    localparam int TERM_BITS = NUM_GRP * ROWS;

    logic [NUM_TERMS*TERM_BITS-1:0] lut_flat;
    logic [ROWS-1:0]                glue_tab;
    logic [NUM_TERMS-1:0]           term_hit;
    logic                           glue_ok;
    arm_state_e                     state_q, state_d;
    logic                           trig_q;

    trig_lut_store #(.NUM_GRP(NUM_GRP)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .wr_en       (wr_en),
        .wr_row      (wr_row),
        .wr_lut_bits (wr_lut_bits),
        .wr_glue_bit (wr_glue_bit),
        .lut_flat    (lut_flat),
        .glue_tab    (glue_tab)
    );

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        trig_term_eval #(.NUM_GRP(NUM_GRP)) u_term (
            .samp (samp_in),
            .tabs (lut_flat[t*TERM_BITS +: TERM_BITS]),
            .term (term_hit[t])
        );
    end

    trig_glue u_glue (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .slot_cur (term_hit[NUM_TERMS-1:1]),
        .glue_tab (glue_tab),
        .glue_ok  (glue_ok)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  state_d = arm ? ST_WATCH : ST_LOAD;
            ST_WATCH: state_d = arm ? ST_WATCH : ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= (state_q == ST_WATCH) && arm && term_hit[TERM_VM] && glue_ok;
        end
    end

    assign trig_out = trig_q;

    // R5: a pulse needs the value/mask term on the sample before it
    a_r5_needs_value: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> $past(term_hit[TERM_VM]));

    // R9: disarming silences the next cycle
    a_r9_disarm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !trig_out);

    // R9: the priming sample never fires
    a_r9_prime_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm) |=> !trig_out);
endmodule

// File: tb/trig_lut_eval_tb.sv
module trig_lut_eval_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_row = '0;
    logic [11:0] wr_lut_bits = '0;
    logic        wr_glue_bit = 1'b0;
    logic [15:0] samp_in = '0;
    logic        trig_out;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    string cur_req = "R1";

    logic [15:0] h_tab [3][4];
    logic [15:0] h_glue;
    logic [15:0] m_tab [3][4];
    logic [15:0] m_glue;
    bit          m_watch;
    bit [1:0]    m_prev;
    bit          exp_trig;

    always #2.5 clk = ~clk;

    trig_lut_eval u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .wr_en(wr_en), .wr_row(wr_row),
        .wr_lut_bits(wr_lut_bits), .wr_glue_bit(wr_glue_bit),
        .samp_in(samp_in), .trig_out(trig_out)
    );

    function automatic bit term_of(int t, logic [15:0] s);
        bit r = 1;
        for (int g = 0; g < 4; g++) begin
            if (!m_tab[t][g][s[4*g +: 4]]) r = 0;
        end
        return r;
    endfunction

    // behavioural reference, advanced on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_watch = 0; m_prev = 0; exp_trig = 0; m_glue = 0;
            for (int t = 0; t < 3; t++) for (int g = 0; g < 4; g++) m_tab[t][g] = 0;
        end else begin
            bit vm, s0, s1, gl;
            int idx;
            vm = term_of(0, samp_in);
            s0 = term_of(1, samp_in);
            s1 = term_of(2, samp_in);
            idx = m_prev[0] + 2 * s0 + 4 * m_prev[1] + 8 * s1;
            gl = (m_glue == 0) || m_glue[idx];
            exp_trig = m_watch && arm && vm && gl;
            if (arm) m_prev = {s1, s0};
            m_watch = arm;
            if (wr_en && !arm) begin
                for (int t = 0; t < 3; t++)
                    for (int g = 0; g < 4; g++)
                        m_tab[t][g][wr_row] = wr_lut_bits[t*4+g];
                m_glue[wr_row] = wr_glue_bit;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            compared++;
            if (trig_out !== exp_trig) begin
                mismatched++;
                $display("FAIL %s: trig_out=%0b expected %0b at %0t", cur_req, trig_out, exp_trig, $time);
            end
        end
    end

    task automatic chk(string req, logic act, logic expv);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s: trig_out=%0b expected %0b (directed)", req, act, expv);
        end
    endtask

    task automatic step(logic [15:0] s, logic a, logic expv, string req);
        @(negedge clk);
        cur_req = req; samp_in = s; arm = a;
        @(posedge clk); #1;
        chk(req, trig_out, expv);
    endtask

    task automatic write_row(int row);
        @(negedge clk);
        wr_en = 1; wr_row = row[3:0]; wr_glue_bit = h_glue[row];
        for (int t = 0; t < 3; t++)
            for (int g = 0; g < 4; g++)
                wr_lut_bits[t*4+g] = h_tab[t][g][row];
    endtask

    task automatic program_all();
        for (int r = 0; r < 16; r++) write_row(r);
        @(negedge clk); wr_en = 0;
    endtask

    function automatic logic [15:0] vm_rows(logic [3:0] val, logic [3:0] mask);
        logic [15:0] r = 0;
        for (int j = 0; j < 16; j++) r[j] = (((j[3:0] ^ val) & mask) == 0);
        return r;
    endfunction

    task automatic set_term(int t, logic [15:0] val, logic [15:0] mask);
        for (int g = 0; g < 4; g++) h_tab[t][g] = vm_rows(val[4*g +: 4], mask[4*g +: 4]);
    endtask

    task automatic clear_term(int t);
        for (int g = 0; g < 4; g++) h_tab[t][g] = 0;
    endtask

    task automatic set_glue(bit r0, bit f0, bit r1, bit f1);
        for (int i = 0; i < 16; i++) begin
            bit p0, c0, p1, c1;
            p0 = i[0]; c0 = i[1]; p1 = i[2]; c1 = i[3];
            h_glue[i] = (r0 && !p0 && c0) || (f0 && p0 && !c0) ||
                        (r1 && !p1 && c1) || (f1 && p1 && !c1);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        summary();
    end

    initial begin
        h_glue = 0;
        for (int t = 0; t < 3; t++) clear_term(t);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        chk("R1", trig_out, 1'b0);

        // R1: empty tables never fire
        step(16'hFFFF, 1, 0, "R1");
        step(16'h0000, 1, 0, "R1");
        step(16'hFFFF, 1, 0, "R1");
        step(16'h0000, 0, 0, "R1");

        // R2/R6: value/mask across groups 0 and 2, empty glue
        set_term(0, 16'h020A, 16'h020F);
        program_all();
        step(16'h020A, 1, 0, "R9");
        step(16'h020A, 1, 1, "R6");
        step(16'hF2FA, 1, 1, "R2");
        step(16'h000A, 1, 0, "R2");
        step(16'h020B, 1, 0, "R2");
        cur_req = "R2";
        for (int i = 0; i < 200; i++) begin
            logic [15:0] s;
            @(negedge clk);
            s = $urandom;
            if (i % 3 == 0) s = (s & ~16'h020F) | 16'h020A;
            samp_in = s;
        end
        step(16'h020A, 0, 0, "R9");

        // R8: full reload attempt while armed
        @(negedge clk); arm = 1; samp_in = 16'h020A; cur_req = "R8";
        for (int r = 0; r < 16; r++) begin
            @(negedge clk);
            wr_en = 1; wr_row = r[3:0]; wr_lut_bits = '0; wr_glue_bit = 1;
        end
        @(negedge clk); wr_en = 0;
        step(16'h020A, 1, 1, "R8");
        step(16'h020A, 0, 0, "R9");

        // R4: slot0 rising on ch5, slot1 falling on ch14
        set_term(0, 16'h0000, 16'h0000);
        set_term(1, 16'h0020, 16'h0020);
        set_term(2, 16'h4000, 16'h4000);
        set_glue(1, 0, 0, 1);
        program_all();
        step(16'h0000, 1, 0, "R9");
        step(16'h0020, 1, 1, "R4");
        step(16'h0020, 1, 0, "R5");
        step(16'h4020, 1, 0, "R4");
        step(16'h0020, 1, 1, "R4");
        step(16'h0000, 1, 0, "R4");
        cur_req = "R4";
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            samp_in = $urandom;
        end

        // R3: value/mask term gates edge slots
        set_term(0, 16'h0001, 16'h0001);
        step(16'h0000, 0, 0, "R9");
        program_all();
        step(16'h0001, 1, 0, "R9");
        step(16'h0021, 1, 1, "R3");
        step(16'h0001, 1, 0, "R3");
        step(16'h0020, 1, 0, "R3");
        step(16'h0000, 0, 0, "R9");

        // R7: single-row tables and a single-row update
        set_term(0, 16'h0000, 16'h0000);
        h_tab[0][0] = 16'h0040;
        clear_term(1); clear_term(2); h_glue = 0;
        program_all();
        step(16'h0006, 1, 0, "R9");
        step(16'h0006, 1, 1, "R7");
        step(16'h0007, 1, 0, "R7");
        step(16'hFFF6, 1, 1, "R7");
        step(16'h0007, 0, 0, "R9");
        h_tab[0][0][7] = 1'b1;
        write_row(7);
        @(negedge clk); wr_en = 0;
        step(16'h0007, 1, 0, "R9");
        step(16'h0007, 1, 1, "R7");
        step(16'h0005, 1, 0, "R7");
        step(16'h0006, 1, 1, "R7");

        // R9: disarm and re-prime
        step(16'h0007, 0, 0, "R9");
        step(16'h0007, 1, 0, "R9");
        step(16'h0007, 1, 1, "R5");
        step(16'h0007, 1, 1, "R5");

        @(negedge clk); arm = 0;
        @(negedge clk);
        summary();
    end
endmodule